// File: doc/BRIEF.md
# Triple-Sample Asynchronous Serial Receiver

This block recovers 8-bit or 9-bit words from a single asynchronous serial line. It rests idle with the line high and waits for a falling edge. That edge starts a frame: the done flag and the error flag are both cleared, edge detection is switched off for the rest of the frame, and a half-bit timer is started. The timer runs only while a frame is in progress. It counts half-bit intervals, and the line is examined only while the count is odd. Those intervals lie over the centre of each bit cell.

In every odd interval the line is sampled three times: a quarter of a half-bit before the cell centre, at the centre, and a quarter after it. A bit is accepted only when all three samples agree. There is no majority vote. Any disagreement, a start bit that reads high, or a stop bit that reads low raises the error flag and returns the block to idle. A frame that ends correctly latches the word, least significant bit first, onto the data output and raises the done flag. Edge detection is then armed again at once, so frames may follow each other with no idle gap. The word length is chosen per frame from a mode input, which is latched when the frame starts.

Top module: `trisample_rx`

## Requirements
- R1: While reset is held and after it is released, rx_done and rx_err are 0 and rx_data is all zeros.
- R2: A falling edge on rx_line while idle starts a frame, and both rx_done and rx_err read 0 from then until that frame ends.
- R3: With wide_mode low at the start edge, the frame is one low start bit, eight data bits least significant first, and one high stop bit. rx_data then holds the eight bits in positions 7:0 with bit 8 at 0, and rx_done is 1 before the stop bit cell ends.
- R4: With wide_mode high at the start edge, nine data bits are received, least significant first, into rx_data 8:0.
- R5: Each bit is sampled three times, centred in its cell. If any sample differs from the others, rx_err is set, rx_done stays 0, and the block returns to idle.
- R6: A start bit that samples high sets rx_err and returns the block to idle. A single-cycle low glitch on an idle line produces this case.
- R7: A stop bit that samples low sets rx_err, leaves rx_done at 0, and leaves rx_data unchanged.
- R8: rx_err stays set until the next start edge. rx_data changes only when a frame completes.
- R9: Falling edges inside a frame do not restart reception. Edge detection is re-armed after the stop bit, so a start bit that directly follows a stop bit is received.
- R10: The half-bit counter is held at zero while the block is idle.
- R11: A change of wide_mode during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial line, high when idle |
| wide_mode | input | 1 | 1 selects 9 data bits, 0 selects 8; latched at the start edge |
| rx_data | output | DATA_W | Last correctly received word |
| rx_done | output | 1 | Set when a frame completes; cleared at the next start edge |
| rx_err | output | 1 | Set on a sample disagreement, a bad start bit or a bad stop bit; cleared at the next start edge |

## Verification
The receive path is driven with words whose bit patterns are dense in internal falling edges (0xA5, 0x155, 0x3C). These show whether edge detection really stays disarmed inside a frame. Frames sent back to back show whether it is re-armed in time after the stop bit. Single-cycle inversions are placed on the middle sample of a data bit and of the start bit. These separate strict unanimity from a majority vote, which would accept the bit without error. An idle glitch, a low stop bit, and a mode change in mid-frame each show whether the start check, the stop check and the mode latch act on their own, and whether a failed frame leaves the previous word in place.

// File: rtl/trisample_rx_pkg.sv
package trisample_rx_pkg;
  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_RUN  = 1'b1
  } rx_state_t;
endpackage

// File: rtl/trisample_rx_sync.sv
// Synchronizer chain for the serial input plus a falling-edge detector.
module trisample_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic line,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= chain[STAGES-1];
  end

  assign line = chain[STAGES-1];
  assign fall = prev & ~chain[STAGES-1];
endmodule

// File: rtl/trisample_rx_timer.sv
// Half-bit timer that runs only while a frame is in progress.
// The first interval after the load is half a half-bit long, so every odd
// interval covers the middle half of a bit cell.
module trisample_rx_timer #(
  parameter int HALF  = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  output logic [CNT_W-1:0] hcnt,
  output logic             smp,
  output logic             smp_first,
  output logic             smp_last
);
  localparam int DIV_W = (HALF > 2) ? $clog2(HALF) : 1;
  localparam int QTR   = HALF / 4;

  logic [DIV_W-1:0] div;
  logic             odd;

  always_ff @(posedge clk) begin
    if (rst || (!run && !load)) begin
      div  <= '0;
      hcnt <= '0;
    end else if (load) begin
      div  <= DIV_W'(HALF / 2);
      hcnt <= '0;
    end else if (div == DIV_W'(HALF - 1)) begin
      div  <= '0;
      hcnt <= hcnt + 1'b1;
    end else begin
      div  <= div + 1'b1;
    end
  end

  assign odd       = run & hcnt[0];
  assign smp_first = odd && (div == DIV_W'(QTR));
  assign smp_last  = odd && (div == DIV_W'(3 * QTR));
  assign smp       = odd && ((div == DIV_W'(QTR)) ||
                             (div == DIV_W'(2 * QTR)) ||
                             (div == DIV_W'(3 * QTR)));
endmodule

// File: rtl/trisample_rx_vote.sv
// Unanimity check over the three samples of one bit cell.
module trisample_rx_vote (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic smp,
  input  logic smp_first,
  input  logic smp_last,
  output logic bit_ok,
  output logic bit_bad,
  output logic bit_val
);
  logic first_q;
  logic mis_q;
  logic differ;

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q <= 1'b0;
      mis_q   <= 1'b0;
    end else if (smp_first) begin
      first_q <= line;
      mis_q   <= 1'b0;
    end else if (smp && (line != first_q)) begin
      mis_q   <= 1'b1;
    end
  end

  assign differ  = mis_q | (line != first_q);
  assign bit_val = first_q;
  assign bit_bad = smp_last & differ;
  assign bit_ok  = smp_last & ~differ;
endmodule

// File: rtl/trisample_rx.sv
module trisample_rx
  import trisample_rx_pkg::*;
#(
  parameter int HALF_BIT_CYCLES = 8,
  parameter int DATA_W          = 9,
  parameter int SYNC_STAGES     = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_line,
  input  logic              wide_mode,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_done,
  output logic              rx_err
);
  localparam int CNT_W = $clog2(2 * (DATA_W + 2) + 1);
  localparam int IDX_W = CNT_W - 1;

  rx_state_t         state;
  logic              line_s, fall;
  logic              load, busy;
  logic [CNT_W-1:0]  hcnt;
  logic              smp, smp_first, smp_last;
  logic              bit_ok, bit_bad, bit_val;
  logic              mode_q;
  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx, nbits;

  trisample_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rx_line),
    .line(line_s),
    .fall(fall)
  );

  assign busy = (state == RX_RUN);
  assign load = (state == RX_IDLE) && fall;

  trisample_rx_timer #(.HALF(HALF_BIT_CYCLES), .CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .run      (busy),
    .hcnt     (hcnt),
    .smp      (smp),
    .smp_first(smp_first),
    .smp_last (smp_last)
  );

  trisample_rx_vote u_vote (
    .clk      (clk),
    .rst      (rst),
    .line     (line_s),
    .smp      (smp),
    .smp_first(smp_first),
    .smp_last (smp_last),
    .bit_ok   (bit_ok),
    .bit_bad  (bit_bad),
    .bit_val  (bit_val)
  );

  // Bit cell index: 0 = start, 1..nbits = data, nbits+1 = stop.
  assign idx   = hcnt[CNT_W-1:1];
  assign nbits = mode_q ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      rx_done <= 1'b0;
      rx_err  <= 1'b0;
      rx_data <= '0;
      shreg   <= '0;
      mode_q  <= 1'b0;
    end else begin
      case (state)
        RX_IDLE: begin
          if (fall) begin
            state   <= RX_RUN;
            rx_done <= 1'b0;
            rx_err  <= 1'b0;
            mode_q  <= wide_mode;
            shreg   <= '0;
          end
        end
        RX_RUN: begin
          if (bit_bad) begin
            rx_err <= 1'b1;
            state  <= RX_IDLE;
          end else if (bit_ok) begin
            if (idx == '0) begin
              if (bit_val) begin
                rx_err <= 1'b1;
                state  <= RX_IDLE;
              end
            end else if (idx <= nbits) begin
              shreg <= {bit_val, shreg[DATA_W-1:1]};
            end else begin
              if (!bit_val) begin
                rx_err <= 1'b1;
              end else begin
                rx_done <= 1'b1;
                rx_data <= mode_q ? shreg : (shreg >> 1);
              end
              state <= RX_IDLE;
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/trisample_rx_chk.sv
module trisample_rx_chk #(
  parameter int DATA_W = 9,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_done,
  input logic              rx_err,
  input logic              busy,
  input logic [CNT_W-1:0]  hcnt
);
  // A failed frame never reports completion.
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(rx_done && rx_err));

  // Both flags read 0 once a frame has started.
  assert_flags_clear_at_start_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!rx_done && !rx_err));

  // The error flag drops only because a new frame started.
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_err) |-> busy);

  // The data output moves only together with a completion.
  assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$rose(rx_done) |-> $stable(rx_data));

  // Completion is reported when a frame ends.
  assert_done_at_frame_end_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_done) |-> ($past(busy) && !busy));

  // The half-bit counter rests at zero while idle.
  assert_cnt_idle_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> (hcnt == '0));
endmodule

bind trisample_rx trisample_rx_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .rx_data(rx_data),
  .rx_done(rx_done),
  .rx_err (rx_err),
  .busy   (busy),
  .hcnt   (hcnt)
);

// File: tb/test_trisample_rx.sv
module test_trisample_rx;
  localparam int HALF = 8;
  localparam int BITC = 2 * HALF;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_line = 1'b1;
  logic       wide_mode = 1'b0;
  logic [8:0] rx_data;
  logic       rx_done;
  logic       rx_err;

  int   n_tests = 0;
  int   n_fail  = 0;
  bit   ended   = 1'b0;
  logic [8:0] last_good = '0;

  always #5 clk = ~clk;

  trisample_rx #(.HALF_BIT_CYCLES(HALF), .DATA_W(9), .SYNC_STAGES(2)) i_trisample_rx (
    .clk      (clk),
    .rst      (rst),
    .rx_line  (rx_line),
    .wide_mode(wide_mode),
    .rx_data  (rx_data),
    .rx_done  (rx_done),
    .rx_err   (rx_err)
  );

  task automatic chk(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drives one frame; gbit >= 0 inverts the middle sample of that bit cell and
  // aborts the frame after it. stopv is the stop bit level. flip drops
  // wide_mode after the start bit.
  task automatic send_frame(input logic [8:0] v, input int nb, input int gbit,
                            input bit stopv, input bit flip, input string tag);
    logic [8:0] exp;
    for (int k = 0; k <= nb + 1; k++) begin
      logic bv;
      bv = (k == 0) ? 1'b0 : (k <= nb) ? v[k-1] : stopv;
      for (int c = 0; c < BITC; c++) begin
        @(negedge clk);
        rx_line = (k == gbit && c == 9) ? ~bv : bv;
        if (flip && k == 1 && c == 0) wide_mode = 1'b0;
      end
      if (k == 0 && gbit != 0)
        chk(!rx_done && !rx_err, "R2 flags cleared at start", {10'b0, rx_done, rx_err}, 12'h0);
      if (k == gbit) begin
        @(negedge clk);
        rx_line = 1'b1;
        repeat (3) @(negedge clk);
        chk(rx_err && !rx_done, {tag, " sample disagreement"}, {10'b0, rx_done, rx_err}, 12'h1);
        chk(rx_data == last_good, {tag, " data kept"}, {3'b0, rx_data}, {3'b0, last_good});
        return;
      end
    end
    if (stopv) begin
      exp = (nb == 8) ? {1'b0, v[7:0]} : v;
      chk(rx_done && !rx_err, {tag, " done flag"}, {10'b0, rx_done, rx_err}, 12'h2);
      chk(rx_data == exp, {tag, " data word"}, {3'b0, rx_data}, {3'b0, exp});
      last_good = exp;
    end else begin
      @(negedge clk);
      rx_line = 1'b1;
      repeat (4) @(negedge clk);
      chk(rx_err && !rx_done, "R7 low stop bit", {10'b0, rx_done, rx_err}, 12'h1);
      chk(rx_data == last_good, "R7 data kept", {3'b0, rx_data}, {3'b0, last_good});
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    rx_line = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(!rx_done && !rx_err && rx_data == '0, "R1 reset state", {1'b0, rx_done, rx_err, rx_data}, 12'h0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rx_done && !rx_err && rx_data == '0, "R1 after release", {1'b0, rx_done, rx_err, rx_data}, 12'h0);
    idle(10);
  endtask

  task automatic t_byte();       // R3, R9: internal falling edges
    wide_mode = 1'b0;
    send_frame(9'h0A5, 8, -1, 1'b1, 1'b0, "R3 byte 0xA5");
    idle(8);
  endtask

  task automatic t_back_to_back();  // R9: next start right after stop
    send_frame(9'h03C, 8, -1, 1'b1, 1'b0, "R9 first of pair");
    send_frame(9'h001, 8, -1, 1'b1, 1'b0, "R9 second of pair");
    idle(8);
  endtask

  task automatic t_nine();       // R4
    wide_mode = 1'b1;
    send_frame(9'h1A5, 9, -1, 1'b1, 1'b0, "R4 nine-bit 0x1A5");
    wide_mode = 1'b0;
    idle(8);
  endtask

  task automatic t_glitch_data();  // R5: one odd sample in data bit 3
    send_frame(9'h0FF, 8, 4, 1'b1, 1'b0, "R5 data glitch");
    idle(40);
    chk(rx_err && !rx_done, "R8 error persists while idle", {10'b0, rx_done, rx_err}, 12'h1);
  endtask

  task automatic t_glitch_start();  // R5, R6: odd sample in the start bit
    send_frame(9'h000, 8, 0, 1'b1, 1'b0, "R6 start glitch");
    idle(20);
  endtask

  task automatic t_idle_pulse();  // R6: start bit samples high
    @(negedge clk);
    rx_line = 1'b0;
    @(negedge clk);
    rx_line = 1'b1;
    repeat (BITC + 4) @(negedge clk);
    chk(rx_err && !rx_done, "R6 idle glitch rejected", {10'b0, rx_done, rx_err}, 12'h1);
    chk(rx_data == last_good, "R6 data kept", {3'b0, rx_data}, {3'b0, last_good});
    idle(10);
  endtask

  task automatic t_stop_low();   // R7, R8
    send_frame(9'h055, 8, -1, 1'b0, 1'b0, "R7");
    idle(40);
    chk(rx_err && rx_data == last_good, "R8 error and data held", {2'b0, rx_err, rx_data}, {2'b0, 1'b1, last_good});
    send_frame(9'h00F, 8, -1, 1'b1, 1'b0, "R8 recovery frame");
    idle(8);
  endtask

  task automatic t_mode_flip();  // R11
    wide_mode = 1'b1;
    send_frame(9'h155, 9, -1, 1'b1, 1'b1, "R11 mode change ignored");
    idle(8);
    wide_mode = 1'b0;
    send_frame(9'h180, 8, -1, 1'b1, 1'b0, "R3 byte 0x80 top bit zero");
    idle(8);
  endtask

  initial begin
    t_reset();
    t_byte();
    t_back_to_back();
    t_nine();
    t_glitch_data();
    t_glitch_start();
    t_idle_pulse();
    t_stop_low();
    t_mode_flip();
    if (!ended) begin
      ended = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule